// File: doc/BRIEF.md
# Serial EEPROM Write-Completion Poll Sequencer

After a write, a serial EEPROM stays busy with its internal programming cycle and does not answer its bus address. This block sits above a byte-level I2C master engine and takes the next operation as one command. It then waits out that busy time. Each probe it sends is the opening byte of the next operation: a start condition and the device-select byte with the direction bit clear. A refused probe is repeated. An accepted probe already counts as the first byte of the new transfer, so the sequencer goes straight on with the word address. A write then sends its data bytes. A random read issues a repeated start, sends the select byte for reading and collects the data. An empty operation just closes the bus with a stop.

The user presents a command with a 7-bit device address, a word address, a byte count and a limit on poll attempts. The command is taken only while the block is idle. Write bytes are pulled one at a time through a take strobe. Read bytes come out with a valid strobe. Completion is a single-cycle done pulse, with separate flags for a poll timeout and for a refused byte later in the transfer.

The controller is one state machine with these states:
- IDLE
- PSTART (poll start)
- PSEL (poll select byte)
- ADDR (word address bytes)
- WDATA (write data)
- RSTART (repeated start)
- RSEL (read select byte)
- RDATA (receive data)
- STOP
- DONE

Transitions:
- IDLE→PSTART when a command is taken.
- PSTART→PSEL.
- PSEL→PSTART on a refusal below the limit.
- PSEL→STOP on a refusal at the limit.
- PSEL→ADDR on acceptance for a write or a read.
- PSEL→STOP on acceptance with nothing to do.
- ADDR→ADDR while more address bytes remain.
- ADDR→WDATA for a write, or ADDR→RSTART for a read.
- WDATA→WDATA until the last data byte, then WDATA→STOP.
- RSTART→RSEL.
- RSEL→RDATA.
- RDATA→RDATA until the last byte, then RDATA→STOP.
- ADDR, WDATA and RSEL go to STOP on a refusal.
- STOP→DONE.
- DONE→IDLE.

Every engine state issues its engine command once, then waits for the engine's completion strobe before it moves.

Top module: `eeprom_poll_seq`

## Requirements
- R1: After reset the block is idle: busy and done are low and no engine command strobe is asserted.
- R2: Each poll attempt is an engine start followed by a send of the byte {device address, 0}. When the engine reports that this byte was not acknowledged, the next attempt begins with another start.
- R3: When the poll byte is acknowledged and the operation code is 2'b01 (write), the block sends the word address bytes, most significant first, and then cmd_len+1 data bytes. It does not resend the select byte. wr_take pulses once in the cycle each data byte is handed to the engine.
- R4: When the poll byte is acknowledged and the operation code is 2'b10 (random read), the block sends the word address and issues a repeated start. It then sends {device address, 1} and receives cmd_len+1 bytes, each presented on rd_byte with a one-cycle rd_valid.
- R5: During a read, every received byte except the last is requested with eng_ack_out high. The last is requested with eng_ack_out low.
- R6: When the poll byte is acknowledged and the operation code is 2'b00 or 2'b11 (no operation), the block issues a stop and nothing else.
- R7: When poll_limit attempts go unacknowledged, the block issues a stop and reports err_timeout. A limit of 0 behaves as 1.
- R8: A refused word address byte, write data byte or read select byte after a successful poll ends the operation with a stop and sets err_nack.
- R9: busy is high from the cycle after a command is taken until the final stop completes. done then pulses high for exactly one cycle with busy low. The error flags are valid at done and hold until the next command is taken.
- R10: cmd_valid has no effect while a command is in progress.
- R11: At most one engine command strobe is asserted in any cycle. A new command is issued only after the engine has signalled completion of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | Next operation: 00 none, 01 write, 10 random read, 11 none |
| cmd_dev | input | 7 | 7-bit device address |
| cmd_addr | input | 8*ADDR_BYTES | Memory word address |
| cmd_len | input | LEN_W | Data byte count minus one |
| poll_limit | input | POLL_W | Maximum number of poll attempts |
| wr_byte | input | 8 | Current write data byte |
| wr_take | output | 1 | Write byte consumed this cycle |
| rd_byte | output | 8 | Received read byte |
| rd_valid | output | 1 | rd_byte valid this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Poll limit exhausted |
| err_nack | output | 1 | Byte refused after successful poll |
| eng_start | output | 1 | Engine: issue start condition |
| eng_restart | output | 1 | Engine: issue repeated start |
| eng_stop | output | 1 | Engine: issue stop condition |
| eng_send | output | 1 | Engine: transmit eng_tx |
| eng_recv | output | 1 | Engine: receive one byte |
| eng_tx | output | 8 | Byte to transmit |
| eng_ack_out | output | 1 | Master acknowledge for the received byte |
| eng_done | input | 1 | Engine finished the current command |
| eng_nack | input | 1 | Transmitted byte was not acknowledged (with eng_done) |
| eng_rx | input | 8 | Received byte (with eng_done) |

## Verification
Several properties are checked on every cycle:
- The engine strobes stay mutually exclusive and absent while idle.
- The select byte carries direction 0 during polling and 1 after the repeated start.
- A write byte is taken only together with a send.
- done is a lone one-cycle pulse with busy low, and an accepted command raises busy.

Other behaviour only the bench scenarios can show, using an EEPROM model that refuses a chosen number of probes:
- how many attempts are made before success or timeout,
- that the select byte is never repeated after acceptance,
- the byte counts, the memory contents and the read data,
- the placement of the final master no-acknowledge,
- the error reporting for each refused byte position.

// File: rtl/eeprom_poll_pkg.sv
package eeprom_poll_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_PSTART = 4'd1,
        S_PSEL   = 4'd2,
        S_ADDR   = 4'd3,
        S_WDATA  = 4'd4,
        S_RSTART = 4'd5,
        S_RSEL   = 4'd6,
        S_RDATA  = 4'd7,
        S_STOP   = 4'd8,
        S_DONE   = 4'd9
    } state_e;

endpackage

// File: rtl/eps_poll_ctr.sv
// Counts unacknowledged poll attempts against a limit captured at command time.
module eps_poll_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] limit,
    input  logic         step,
    output logic         last
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= limit;
        end else if (step && (cnt_q != {W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the attempt now in flight is the last allowed one
    assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_q};
endmodule

// File: rtl/eps_len_ctr.sv
// Counts transferred data bytes; flags the final byte of the burst.
module eps_len_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    input  logic         step,
    output logic         last
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            len_q <= len;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == len_q);
endmodule

// File: rtl/eeprom_poll_seq.sv
module eeprom_poll_seq
    import eeprom_poll_pkg::*;
#(
    parameter int ADDR_BYTES = 1,
    parameter int LEN_W      = 4,
    parameter int POLL_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [6:0]              cmd_dev,
    input  logic [8*ADDR_BYTES-1:0] cmd_addr,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [POLL_W-1:0]       poll_limit,
    input  logic [7:0]              wr_byte,
    output logic                    wr_take,
    output logic [7:0]              rd_byte,
    output logic                    rd_valid,
    output logic                    busy,
    output logic                    done,
    output logic                    err_timeout,
    output logic                    err_nack,
    output logic                    eng_start,
    output logic                    eng_restart,
    output logic                    eng_stop,
    output logic                    eng_send,
    output logic                    eng_recv,
    output logic [7:0]              eng_tx,
    output logic                    eng_ack_out,
    input  logic                    eng_done,
    input  logic                    eng_nack,
    input  logic [7:0]              eng_rx
);
    localparam int AW  = 8 * ADDR_BYTES;
    localparam int ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ABW-1:0] ABYTE_LAST = ABW'(ADDR_BYTES - 1);

    state_e         state_q, state_d;
    logic           issued_q, issued_d;
    logic [6:0]     dev_q;
    op_e            op_q;
    logic [AW-1:0]  addr_q;
    logic [ABW-1:0] abyte_q;
    logic           err_to_q, err_nk_q;
    logic           set_to, set_nk;

    logic           accept;
    logic           fin;
    logic           go;
    logic           poll_last;
    logic           data_last;
    logic           poll_step;
    logic           data_step;
    logic           abyte_step;
    logic [7:0]     addr_byte;

    assign accept = (state_q == S_IDLE) && cmd_valid;
    assign fin    = issued_q && eng_done;
    assign go     = !issued_q;

    // ---------------- counters ----------------
    eps_poll_ctr #(.W(POLL_W)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .limit (poll_limit),
        .step  (poll_step),
        .last  (poll_last)
    );

    eps_len_ctr #(.W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .len   (cmd_len),
        .step  (data_step),
        .last  (data_last)
    );

    assign poll_step  = (state_q == S_PSEL) && fin && eng_nack;
    assign data_step  = fin && (((state_q == S_WDATA) && !eng_nack) || (state_q == S_RDATA));
    assign abyte_step = (state_q == S_ADDR) && fin && !eng_nack;

    // word address byte selection, most significant first
    always_comb begin
        addr_byte = addr_q[7:0];
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (abyte_q == ABW'(i)) begin
                addr_byte = addr_q[8*(ADDR_BYTES-1-i) +: 8];
            end
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            issued_q <= 1'b0;
            dev_q    <= '0;
            op_q     <= OP_NONE;
            addr_q   <= '0;
            abyte_q  <= '0;
            err_to_q <= 1'b0;
            err_nk_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            issued_q <= issued_d;
            if (accept) begin
                dev_q    <= cmd_dev;
                op_q     <= op_e'(cmd_op);
                addr_q   <= cmd_addr;
                abyte_q  <= '0;
                err_to_q <= 1'b0;
                err_nk_q <= 1'b0;
            end else begin
                if (abyte_step && (abyte_q != ABYTE_LAST)) abyte_q <= abyte_q + 1'b1;
                if (set_to) err_to_q <= 1'b1;
                if (set_nk) err_nk_q <= 1'b1;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d  = state_q;
        issued_d = issued_q;
        set_to   = 1'b0;
        set_nk   = 1'b0;
        if (state_q != S_IDLE && state_q != S_DONE) begin
            if (!issued_q)   issued_d = 1'b1;
            else if (eng_done) issued_d = 1'b0;
        end
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) state_d = S_PSTART;
            end
            S_PSTART: begin
                if (fin) state_d = S_PSEL;
            end
            S_PSEL: begin
                if (fin) begin
                    if (eng_nack) begin
                        if (poll_last) begin
                            state_d = S_STOP;
                            set_to  = 1'b1;
                        end else begin
                            state_d = S_PSTART;
                        end
                    end else if (op_q == OP_WRITE || op_q == OP_READ) begin
                        state_d = S_ADDR;
                    end else begin
                        state_d = S_STOP;
                    end
                end
            end
            S_ADDR: begin
                if (fin) begin
                    if (eng_nack) begin
                        state_d = S_STOP;
                        set_nk  = 1'b1;
                    end else if (abyte_q == ABYTE_LAST) begin
                        state_d = (op_q == OP_WRITE) ? S_WDATA : S_RSTART;
                    end
                end
            end
            S_WDATA: begin
                if (fin) begin
                    if (eng_nack) begin
                        state_d = S_STOP;
                        set_nk  = 1'b1;
                    end else if (data_last) begin
                        state_d = S_STOP;
                    end
                end
            end
            S_RSTART: begin
                if (fin) state_d = S_RSEL;
            end
            S_RSEL: begin
                if (fin) begin
                    if (eng_nack) begin
                        state_d = S_STOP;
                        set_nk  = 1'b1;
                    end else begin
                        state_d = S_RDATA;
                    end
                end
            end
            S_RDATA: begin
                if (fin && data_last) state_d = S_STOP;
            end
            S_STOP: begin
                if (fin) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d  = S_IDLE;
                issued_d = 1'b0;
            end
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        eng_start   = 1'b0;
        eng_restart = 1'b0;
        eng_stop    = 1'b0;
        eng_send    = 1'b0;
        eng_recv    = 1'b0;
        eng_tx      = 8'h00;
        eng_ack_out = 1'b0;
        wr_take     = 1'b0;
        rd_valid    = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PSTART: eng_start = go;
            S_PSEL: begin
                eng_send = go;
                eng_tx   = {dev_q, 1'b0};
            end
            S_ADDR: begin
                eng_send = go;
                eng_tx   = addr_byte;
            end
            S_WDATA: begin
                eng_send = go;
                wr_take  = go;
                eng_tx   = wr_byte;
            end
            S_RSTART: eng_restart = go;
            S_RSEL: begin
                eng_send = go;
                eng_tx   = {dev_q, 1'b1};
            end
            S_RDATA: begin
                eng_recv    = go;
                eng_ack_out = !data_last;
                rd_valid    = fin;
            end
            S_STOP: eng_stop = go;
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign busy        = (state_q != S_IDLE) && (state_q != S_DONE);
    assign rd_byte     = eng_rx;
    assign err_timeout = err_to_q;
    assign err_nack    = err_nk_q;
endmodule

// File: rtl/eeprom_poll_seq_chk.sv
module eeprom_poll_seq_chk
    import eeprom_poll_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic       err_timeout,
    input logic       err_nack,
    input logic       eng_start,
    input logic       eng_restart,
    input logic       eng_stop,
    input logic       eng_send,
    input logic       eng_recv,
    input logic [7:0] eng_tx,
    input logic       wr_take,
    input logic [3:0] state,
    input logic [6:0] dev
);
    // R11
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_start, eng_restart, eng_stop, eng_send, eng_recv}));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(eng_start || eng_restart || eng_stop || eng_send || eng_recv));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && cmd_valid) |=> busy);

    // R2
    poll_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSEL && eng_send) |-> (eng_tx == {dev, 1'b0}));

    // R4
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RSEL && eng_send) |-> (eng_tx == {dev, 1'b1}));

    // R3
    take_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> eng_send);

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err_timeout && err_nack));
endmodule

bind eeprom_poll_seq eeprom_poll_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .done        (done),
    .err_timeout (err_timeout),
    .err_nack    (err_nack),
    .eng_start   (eng_start),
    .eng_restart (eng_restart),
    .eng_stop    (eng_stop),
    .eng_send    (eng_send),
    .eng_recv    (eng_recv),
    .eng_tx      (eng_tx),
    .wr_take     (wr_take),
    .state       (state_q),
    .dev         (dev_q)
);

// File: tb/tb_eeprom_poll_seq.sv
`timescale 1ns/1ps
module tb_eeprom_poll_seq;
    localparam logic [6:0] MDEV = 7'h50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [6:0] cmd_dev = 7'h00;
    logic [7:0] cmd_addr = 8'h00;
    logic [3:0] cmd_len = 4'd0;
    logic [7:0] poll_limit = 8'd0;
    logic [7:0] wr_byte;
    logic       wr_take, rd_valid, busy_o, done, err_timeout, err_nack;
    logic [7:0] rd_byte, eng_tx;
    logic       eng_start, eng_restart, eng_stop, eng_send, eng_recv, eng_ack_out;
    logic       eng_done = 1'b0;
    logic       eng_nack = 1'b0;
    logic [7:0] eng_rx = 8'h00;

    always #2 clk = ~clk;

    eeprom_poll_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .poll_limit(poll_limit), .wr_byte(wr_byte), .wr_take(wr_take),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .busy(busy_o), .done(done),
        .err_timeout(err_timeout), .err_nack(err_nack),
        .eng_start(eng_start), .eng_restart(eng_restart), .eng_stop(eng_stop),
        .eng_send(eng_send), .eng_recv(eng_recv), .eng_tx(eng_tx),
        .eng_ack_out(eng_ack_out), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_rx(eng_rx)
    );

    // ---------------- EEPROM + byte engine model ----------------
    logic       load = 1'b0;
    int         cfg_busy = 0;
    bit         cfg_nk_addr = 0;
    int         cfg_nk_data = 255;
    logic [7:0] wbase = 8'h00;

    logic [7:0] mem [256];
    int busy_left, starts, restarts, stops, sends, macks, mnacks, overlap, dcount, pend, phase;
    logic [7:0] ptr;
    logic       last_ack;

    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1) eng_done <= 1'b1;
        end
        if (load) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            busy_left <= cfg_busy;
            starts <= 0; restarts <= 0; stops <= 0; sends <= 0;
            macks <= 0; mnacks <= 0; overlap <= 0; dcount <= 0;
            pend <= 0; phase <= 0; last_ack <= 1'b1;
        end else if (eng_start || eng_restart || eng_stop || eng_send || eng_recv) begin
            if (pend > 0) overlap <= overlap + 1;
            pend     <= 2;
            eng_nack <= 1'b0;
            if (eng_start)   begin starts <= starts + 1; phase <= 0; end
            if (eng_restart) begin restarts <= restarts + 1; phase <= 0; end
            if (eng_stop)    stops <= stops + 1;
            if (eng_send) begin
                sends <= sends + 1;
                if (phase == 0) begin
                    if (eng_tx[7:1] != MDEV) eng_nack <= 1'b1;
                    else if (eng_tx[0]) phase <= 3;
                    else if (busy_left > 0) begin
                        busy_left <= busy_left - 1;
                        eng_nack  <= 1'b1;
                    end else phase <= 1;
                end else if (phase == 1) begin
                    if (cfg_nk_addr) eng_nack <= 1'b1;
                    else begin ptr <= eng_tx; phase <= 2; end
                end else if (phase == 2) begin
                    dcount <= dcount + 1;
                    if (dcount == cfg_nk_data) eng_nack <= 1'b1;
                    else begin mem[ptr] <= eng_tx; ptr <= ptr + 1'b1; end
                end else eng_nack <= 1'b1;
            end
            if (eng_recv) begin
                eng_rx   <= mem[ptr];
                ptr      <= ptr + 1'b1;
                last_ack <= eng_ack_out;
                if (eng_ack_out) macks <= macks + 1; else mnacks <= mnacks + 1;
            end
        end
    end

    // write data source and read capture
    int         widx, rd_n;
    logic [7:0] rd_buf [16];
    assign wr_byte = wbase + 8'(widx * 3);
    always @(posedge clk) begin
        if (load) begin widx <= 0; rd_n <= 0; end
        else begin
            if (wr_take) widx <= widx + 1;
            if (rd_valid) begin
                if (rd_n < 16) rd_buf[rd_n] <= rd_byte;
                rd_n <= rd_n + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int op, input logic [6:0] dev, input logic [7:0] addr,
                            input int len, input int limit, input int bsy,
                            input bit nk_addr, input int nk_data, input bit poke);
        int lim, attempts, eff_op, nbytes, exp_sends, exp_rs, wrote, takes, reads, n;
        bit ok, exp_to, exp_nk;
        cfg_busy = bsy; cfg_nk_addr = nk_addr; cfg_nk_data = nk_data;
        wbase = 8'(8'h11 + addr + 8'(len * 5));
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_dev = dev; cmd_addr = addr;
        cmd_len = len[3:0]; poll_limit = limit[7:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 busy after accept", int'(busy_o), 1);
        if (poke) begin
            // R10: a second request while busy must be ignored
            cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = addr + 8'd40; cmd_len = 4'd5;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk("R9 done reached", int'(done), 1);

        lim      = (limit == 0) ? 1 : limit;
        ok       = (dev == MDEV) && (bsy < lim);
        attempts = ok ? bsy + 1 : lim;
        exp_to   = !ok;
        eff_op   = (ok && (op == 1 || op == 2)) ? op : 0;
        nbytes   = len + 1;
        exp_nk = 0; exp_sends = attempts; exp_rs = 0; wrote = 0; takes = 0; reads = 0;
        if (eff_op == 1) begin
            exp_sends++;
            if (nk_addr) exp_nk = 1;
            else begin
                exp_nk = (nk_data < nbytes);
                takes  = exp_nk ? nk_data + 1 : nbytes;
                wrote  = exp_nk ? nk_data : nbytes;
                exp_sends += takes;
            end
        end else if (eff_op == 2) begin
            exp_sends++;
            if (nk_addr) exp_nk = 1;
            else begin exp_rs = 1; exp_sends++; reads = nbytes; end
        end

        chk("R7 err_timeout", int'(err_timeout), int'(exp_to));
        chk("R8 err_nack", int'(err_nack), int'(exp_nk));
        chk("R2 poll attempts", starts, attempts);
        chk("R3 R6 bytes sent", sends, exp_sends);
        chk("R4 repeated starts", restarts, exp_rs);
        chk("R8 single stop", stops, 1);
        chk("R11 no overlap", overlap, 0);
        if (eff_op == 1) begin
            chk("R3 wr_take count", widx, takes);
            for (int i = 0; i < wrote; i++)
                chk("R3 written byte", int'(mem[8'(addr + 8'(i))]), int'(8'(wbase + 8'(i * 3))));
            chk("R3 byte past end intact", int'(mem[8'(addr + 8'(wrote))]),
                int'(8'(addr + 8'(wrote)) ^ 8'h5A));
        end
        chk("R4 reads delivered", rd_n, reads);
        if (reads > 0) begin
            for (int i = 0; i < reads; i++)
                chk("R4 read byte", int'(rd_buf[i]), int'(8'(addr + 8'(i)) ^ 8'h5A));
            chk("R5 master acks", macks, reads - 1);
            chk("R5 master nacks", mnacks, 1);
            chk("R5 last byte nacked", int'(last_ack), 0);
        end
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);
        chk("R9 idle after done", int'(busy_o), 0);
        chk("R9 flag hold", int'(err_timeout), int'(exp_to));
        if (poke) begin
            repeat (10) @(negedge clk);
            chk("R10 ignored request", starts + int'(busy_o), attempts);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", int'(busy_o), 0);
        chk("R1 done at reset", int'(done), 0);
        chk("R1 no strobes", int'(eng_start | eng_restart | eng_stop | eng_send | eng_recv), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", int'(busy_o), 0);

        // near-exhaustive sweep: busy probes x operation x length
        for (int b = 0; b < 4; b++)
            for (int op = 0; op < 4; op++)
                for (int l = 0; l < 3; l++)
                    run_case(op, MDEV, 8'(8'h20 + 8'(b * 16) + 8'(l)), l, 6, b, 0, 255, 0);

        // R7: poll limit boundaries
        run_case(1, MDEV, 8'h80, 1, 5, 5, 0, 255, 0);
        run_case(1, MDEV, 8'h80, 1, 5, 4, 0, 255, 0);
        run_case(2, MDEV, 8'h90, 0, 0, 0, 0, 255, 0);
        run_case(2, MDEV, 8'h90, 0, 0, 1, 0, 255, 0);
        run_case(1, 7'h23, 8'h90, 0, 3, 0, 0, 255, 0);
        // R8: refusal after the poll
        run_case(1, MDEV, 8'hA0, 2, 6, 1, 1, 255, 0);
        run_case(2, MDEV, 8'hA0, 2, 6, 1, 1, 255, 0);
        run_case(1, MDEV, 8'hB0, 3, 6, 2, 0, 1, 0);
        run_case(1, MDEV, 8'hB0, 3, 6, 0, 0, 0, 0);
        // R3 wrap of address pointer, R4 longer read
        run_case(1, MDEV, 8'hFE, 3, 6, 1, 0, 255, 0);
        run_case(2, MDEV, 8'hF8, 7, 6, 2, 0, 255, 0);
        // R10: request while busy
        run_case(1, MDEV, 8'hC0, 2, 6, 2, 0, 255, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule